// File: doc/BRIEF.md
# Front-Panel Memory Access Sequencer

This block is the command engine behind an operator console. In programming mode the operator sets an address and reads or writes memory one word at a time from the switches. Four single-cycle console commands (set address, store word, step forward and read, step back and read) each start a short, fixed, hardwired sequence. The sequence works on two registers that belong to the console: an address register and a data register. It never uses CPU registers. A panel-lock input stops any new command from starting.

In debug mode the switch bank acts as one more register on the buses, but it is not latched. The operator can place the live switch value on the 16-bit data bus, on the address bus, or on both, and any switch change shows up on the bus in the same cycle. Memory, lamp multiplexing and switch debouncing sit outside the block.

Top module: `console_mem_seq`

## Requirements
- R1: After synchronous reset the address register and the data register read 0. `busy`, `done`, both bus enables and both strobes are low, and each bus drives 0 while its enable is low.
- R2: An accepted set-address command copies the switches into the address register at the accepting clock edge. No memory cycle follows. `busy` and `done` are high for the next single cycle, and the block is idle in the cycle after that.
- R3: An accepted store command copies the switches into the data register. For the three cycles after the accepting edge, the address bus carries the address register and the data bus carries the stored word, with both enables high. `mem_wr` is high only in the middle cycle of the three, so memory at that address takes the word.
- R4: An accepted step-forward command adds 1 to the address register at the accepting edge. For the next three cycles the new address is on the address bus with `addr_en` high. `mem_rd` is high only in the second of those cycles, one cycle after the address went out. The data register captures `mem_rdata` at the end of the third cycle, and `done` is high in the fourth cycle.
- R5: Step-back behaves like R4 but subtracts 1 from the address register. The address register wraps modulo 2^16: 0x0000 minus 1 gives 0xFFFF, and 0xFFFF plus 1 gives 0x0000.
- R6: While `panel_lock` is high, no command starts. `busy` stays low, and the address and data registers keep their values.
- R7: A command pulse that arrives while `busy` is high is dropped. It is not queued, and it changes neither register after the running sequence ends.
- R8: When several command inputs pulse in the same cycle, only one is taken, in this priority: set-address, then store, then step-forward, then step-back.
- R9: While `prog_mode` is low, commands are ignored. When the block is idle, `sel_dbus` puts `switches` on `data_bus` with `data_en` high, and `sel_abus` puts `switches` on `addr_bus` with `addr_en` high. A switch change reaches the bus in the same cycle, with no clock edge.
- R10: `mem_rd` and `mem_wr` are never high together, and either strobe is high only while `addr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_mode | input | 1 | 1 = programming mode, 0 = debug mode |
| panel_lock | input | 1 | Blocks new commands while high |
| cmd_load | input | 1 | Set-address command pulse |
| cmd_deposit | input | 1 | Store-word command pulse |
| cmd_exam_next | input | 1 | Step-forward-and-read command pulse |
| cmd_exam_prev | input | 1 | Step-back-and-read command pulse |
| switches | input | 16 | Entry switch value |
| sel_dbus | input | 1 | Debug mode: put switches on data bus |
| sel_abus | input | 1 | Debug mode: put switches on address bus |
| mem_rdata | input | 16 | Read data returned by memory |
| addr_bus | output | 16 | Address bus value |
| addr_en | output | 1 | Address bus driven |
| data_bus | output | 16 | Data bus value |
| data_en | output | 1 | Data bus driven |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last cycle of a sequence |
| par_q | output | 16 | Console address register |
| pdr_q | output | 16 | Console data register |

## Verification
The four commands are exercised with directed patterns first.
- Stepping back from 0x0000 and forward from 0xFFFF separates correct wraparound from a truncated or saturating counter.
- A store followed by reading the same location back separates a real write at the right address from data that only reaches the data register.
- Pulsing all four command inputs together, and then the lower three, tells the priority order apart from any other order.

Random runs then mix the following, and compare the bench model's address, data and memory contents cycle by cycle:
- command combinations and switch values,
- lock and mode toggles,
- extra pulses injected mid-sequence.

This catches off-by-one strobe timing and any command that is wrongly queued.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;

    parameter int unsigned WORD_W_DEF = 16;

    // Operation taken from the console command pulses
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_DEP   = 3'd2,
        OP_EXINC = 3'd3,
        OP_EXDEC = 3'd4
    } op_e;

    // Sequencer timing states: three bus periods then a finish period
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_FIN  = 3'd4
    } st_e;

    typedef struct packed {
        logic load;
        logic dep;
        logic exinc;
        logic exdec;
    } cmd_s;

    // Fixed priority: load, deposit, step forward, step back
    function automatic op_e pick_op(input cmd_s c);
        op_e r;
        if (c.load)       r = OP_LOAD;
        else if (c.dep)   r = OP_DEP;
        else if (c.exinc) r = OP_EXINC;
        else if (c.exdec) r = OP_EXDEC;
        else              r = OP_NONE;
        return r;
    endfunction

    function automatic logic is_exam(input op_e o);
        return (o == OP_EXINC) || (o == OP_EXDEC);
    endfunction

    function automatic logic in_bus_phase(input st_e s);
        return (s == ST_T1) || (s == ST_T2) || (s == ST_T3);
    endfunction

endpackage

// File: rtl/cmseq_cmd_gate.sv
module cmseq_cmd_gate
    import cmseq_pkg::*;
(
    input  cmd_s cmd,
    input  logic prog_mode,
    input  logic lock,
    input  logic busy,
    output op_e  start_op
);
    logic open_gate;

    always_comb begin
        open_gate = prog_mode && !lock && !busy;
        start_op  = open_gate ? pick_op(cmd) : OP_NONE;
    end

endmodule

// File: rtl/cmseq_fsm.sv
module cmseq_fsm
    import cmseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  start_op,
    output st_e  state,
    output op_e  cur_op
);
    st_e st_q;
    op_e op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            op_q <= OP_NONE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_op != OP_NONE) begin
                        op_q <= start_op;
                        st_q <= (start_op == OP_LOAD) ? ST_FIN : ST_T1;
                    end
                end
                ST_T1:   st_q <= ST_T2;
                ST_T2:   st_q <= ST_T3;
                ST_T3:   st_q <= ST_FIN;
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign state  = st_q;
    assign cur_op = op_q;

    // R4
    seq_t1_t2_chk: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_T1 |=> st_q == ST_T2);
    // R4
    seq_t2_t3_chk: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_T2 |=> st_q == ST_T3);
    // R2
    load_short_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && start_op == OP_LOAD) |=> st_q == ST_FIN);
    // R7
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && st_q != ST_FIN) |=> st_q != ST_IDLE);

endmodule

// File: rtl/cmseq_regs.sv
module cmseq_regs
    import cmseq_pkg::*;
#(
    parameter int unsigned W = WORD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  op_e          start_op,
    input  st_e          state,
    input  op_e          cur_op,
    input  logic [W-1:0] sw,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] par,
    output logic [W-1:0] pdr
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] par_q;
    logic [W-1:0] pdr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= '0;
            pdr_q <= '0;
        end else begin
            case (start_op)
                OP_LOAD:  par_q <= sw;
                OP_EXINC: par_q <= par_q + ONE;
                OP_EXDEC: par_q <= par_q - ONE;
                OP_DEP:   pdr_q <= sw;
                default:  ;
            endcase
            if (state == ST_T3 && is_exam(cur_op))
                pdr_q <= rdata;
        end
    end

    assign par = par_q;
    assign pdr = pdr_q;

    // R7
    par_hold_chk: assert property (@(posedge clk) disable iff (rst)
        state != ST_IDLE |=> $stable(par_q));
    // R5
    par_wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
        (start_op == OP_EXDEC && par_q == '0) |=> par_q == '1);
    // R5
    par_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
        (start_op == OP_EXINC && par_q == '1) |=> par_q == '0);

endmodule

// File: rtl/cmseq_bus_drv.sv
module cmseq_bus_drv
    import cmseq_pkg::*;
#(
    parameter int unsigned W = WORD_W_DEF
) (
    input  st_e          state,
    input  op_e          cur_op,
    input  logic         prog_mode,
    input  logic         sel_d,
    input  logic         sel_a,
    input  logic [W-1:0] sw,
    input  logic [W-1:0] par,
    input  logic [W-1:0] pdr,
    output logic [W-1:0] abus,
    output logic         a_en,
    output logic [W-1:0] dbus,
    output logic         d_en,
    output logic         rd,
    output logic         wr
);
    logic seq_on;
    logic dbg_on;

    always_comb begin
        seq_on = in_bus_phase(state) && (cur_op != OP_LOAD);
        dbg_on = !prog_mode && (state == ST_IDLE);
        abus = '0;
        a_en = 1'b0;
        dbus = '0;
        d_en = 1'b0;
        rd   = 1'b0;
        wr   = 1'b0;
        if (seq_on) begin
            a_en = 1'b1;
            abus = par;
            if (cur_op == OP_DEP) begin
                d_en = 1'b1;
                dbus = pdr;
                wr   = (state == ST_T2);
            end else begin
                rd   = (state == ST_T2);
            end
        end else if (dbg_on) begin
            if (sel_a) begin
                a_en = 1'b1;
                abus = sw;
            end
            if (sel_d) begin
                d_en = 1'b1;
                dbus = sw;
            end
        end
    end

endmodule

// File: rtl/console_mem_seq.sv
module console_mem_seq
    import cmseq_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_mode,
    input  logic              panel_lock,
    input  logic              cmd_load,
    input  logic              cmd_deposit,
    input  logic              cmd_exam_next,
    input  logic              cmd_exam_prev,
    input  logic [WORD_W-1:0] switches,
    input  logic              sel_dbus,
    input  logic              sel_abus,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] addr_bus,
    output logic              addr_en,
    output logic [WORD_W-1:0] data_bus,
    output logic              data_en,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] par_q,
    output logic [WORD_W-1:0] pdr_q
);
    cmd_s cmd;
    op_e  start_op;
    op_e  cur_op;
    st_e  state;

    assign cmd  = '{load: cmd_load, dep: cmd_deposit,
                    exinc: cmd_exam_next, exdec: cmd_exam_prev};
    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN);

    cmseq_cmd_gate u_gate (
        .cmd       (cmd),
        .prog_mode (prog_mode),
        .lock      (panel_lock),
        .busy      (busy),
        .start_op  (start_op)
    );

    cmseq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_op (start_op),
        .state    (state),
        .cur_op   (cur_op)
    );

    cmseq_regs #(.W(WORD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .start_op (start_op),
        .state    (state),
        .cur_op   (cur_op),
        .sw       (switches),
        .rdata    (mem_rdata),
        .par      (par_q),
        .pdr      (pdr_q)
    );

    cmseq_bus_drv #(.W(WORD_W)) u_bus (
        .state     (state),
        .cur_op    (cur_op),
        .prog_mode (prog_mode),
        .sel_d     (sel_dbus),
        .sel_a     (sel_abus),
        .sw        (switches),
        .par       (par_q),
        .pdr       (pdr_q),
        .abus      (addr_bus),
        .a_en      (addr_en),
        .dbus      (data_bus),
        .d_en      (data_en),
        .rd        (mem_rd),
        .wr        (mem_wr)
    );

    // R6
    lock_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (panel_lock && !busy) |=> !busy);
    // R9
    dbg_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!prog_mode && !busy) |=> !busy);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R10
    strobe_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> addr_en);
    // R4
    rd_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> ($past(addr_en) && !$past(mem_rd)));
    // R3
    wr_data_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (data_en && $past(data_en)));
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: tb/test_console_mem_seq.sv
`timescale 1ns/1ps
module test_console_mem_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        prog_mode, panel_lock;
    logic        cmd_load, cmd_deposit, cmd_exam_next, cmd_exam_prev;
    logic [15:0] switches;
    logic        sel_dbus, sel_abus;
    logic [15:0] mem_rdata;
    logic [15:0] addr_bus, data_bus, par_q, pdr_q;
    logic        addr_en, data_en, mem_rd, mem_wr, busy, done;

    logic [15:0] mem     [256];
    logic [15:0] ref_mem [256];
    logic [15:0] m_par, m_pdr;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    console_mem_seq i_console_mem_seq (
        .clk(clk), .rst(rst), .prog_mode(prog_mode), .panel_lock(panel_lock),
        .cmd_load(cmd_load), .cmd_deposit(cmd_deposit),
        .cmd_exam_next(cmd_exam_next), .cmd_exam_prev(cmd_exam_prev),
        .switches(switches), .sel_dbus(sel_dbus), .sel_abus(sel_abus),
        .mem_rdata(mem_rdata), .addr_bus(addr_bus), .addr_en(addr_en),
        .data_bus(data_bus), .data_en(data_en), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .busy(busy), .done(done), .par_q(par_q), .pdr_q(pdr_q)
    );

    // Memory model, 256 words aliased on the low address byte
    assign mem_rdata = mem[addr_bus[7:0]];
    always @(posedge clk) if (mem_wr) mem[addr_bus[7:0]] <= data_bus;

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 40503) ^ 16'h5A3C;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic set_cmd(input logic [3:0] c);
        {cmd_load, cmd_deposit, cmd_exam_next, cmd_exam_prev} = c;
    endtask

    // c = {load, deposit, next, prev}; inj pulsed while busy (R7)
    task automatic run_cmd(input logic [3:0] c, input logic [15:0] sw,
                           input logic [3:0] inj, input string note);
        int op;
        logic [15:0] p0, d0;
        p0 = m_par;
        d0 = m_pdr;
        op = 0;
        if (prog_mode && !panel_lock) begin
            if (c[3]) op = 1;
            else if (c[2]) op = 2;
            else if (c[1]) op = 3;
            else if (c[0]) op = 4;
        end
        switches = sw;
        set_cmd(c);
        @(negedge clk);
        set_cmd(4'b0);
        case (op)
            0: begin
                chk({"R6/R9 ignored busy ", note}, {15'b0, busy}, 16'h0);
                chk({"R6/R9 par kept ", note}, par_q, p0);
                chk({"R6/R9 pdr kept ", note}, pdr_q, d0);
                if (!prog_mode) begin
                    chk("R9 dbus live", data_bus, sel_dbus ? sw : 16'h0);
                    chk("R9 aen", {15'b0, addr_en}, {15'b0, sel_abus});
                end
            end
            1: begin
                m_par = sw;
                chk({"R2 par ", note}, par_q, m_par);
                chk({"R2 done ", note}, {14'b0, busy, done}, 16'h3);
                chk({"R2 no cycle ", note}, {12'b0, addr_en, data_en, mem_rd, mem_wr}, 16'h0);
                set_cmd(inj);
                @(negedge clk);
                set_cmd(4'b0);
                chk({"R2/R7 idle ", note}, {15'b0, busy}, 16'h0);
                chk({"R7 par after load ", note}, par_q, m_par);
            end
            2: begin
                m_pdr = sw;
                for (int t = 1; t <= 3; t++) begin
                    chk({"R3 abus ", note}, addr_bus, m_par);
                    chk({"R3 dbus ", note}, data_bus, m_pdr);
                    chk({"R3 en/strobe ", note}, {12'b0, addr_en, data_en, mem_rd, mem_wr},
                        {12'b0, 1'b1, 1'b1, 1'b0, t == 2});
                    if (t == 1) set_cmd(inj);
                    @(negedge clk);
                    if (t == 1) set_cmd(4'b0);
                end
                ref_mem[m_par[7:0]] = m_pdr;
                chk({"R3 done ", note}, {15'b0, done}, 16'h1);
                chk({"R3 pdr ", note}, pdr_q, m_pdr);
                @(negedge clk);
                chk({"R3/R7 idle ", note}, {15'b0, busy}, 16'h0);
                chk({"R7 par ", note}, par_q, m_par);
            end
            default: begin
                m_par = (op == 3) ? m_par + 16'd1 : m_par - 16'd1;
                for (int t = 1; t <= 3; t++) begin
                    chk({(op == 3) ? "R4" : "R5", " abus ", note}, addr_bus, m_par);
                    chk({"R4/R10 en/strobe ", note}, {12'b0, addr_en, data_en, mem_rd, mem_wr},
                        {12'b0, 1'b1, 1'b0, t == 2, 1'b0});
                    if (t == 1) set_cmd(inj);
                    @(negedge clk);
                    if (t == 1) set_cmd(4'b0);
                end
                m_pdr = ref_mem[m_par[7:0]];
                chk({"R4 done ", note}, {15'b0, done}, 16'h1);
                chk({(op == 3) ? "R4" : "R5", " pdr read ", note}, pdr_q, m_pdr);
                @(negedge clk);
                chk({"R7 idle ", note}, {15'b0, busy}, 16'h0);
                chk({"R7 par ", note}, par_q, m_par);
            end
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete (R1..R10 unfinished)");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_word(i);
            ref_mem[i] = init_word(i);
        end
        rst = 1'b1; prog_mode = 1'b1; panel_lock = 1'b0;
        set_cmd(4'b0); switches = 16'h0; sel_dbus = 1'b0; sel_abus = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m_par = 16'h0; m_pdr = 16'h0;
        chk("R1 par", par_q, 16'h0);
        chk("R1 pdr", pdr_q, 16'h0);
        chk("R1 flags", {10'b0, busy, done, addr_en, data_en, mem_rd, mem_wr}, 16'h0);
        chk("R1 buses", addr_bus | data_bus, 16'h0);

        // Wraparound
        run_cmd(4'b1000, 16'h0000, 4'b0, "");
        run_cmd(4'b0001, 16'h0, 4'b0, "wrap down");
        chk("R5 wrap to FFFF", par_q, 16'hFFFF);
        run_cmd(4'b0010, 16'h0, 4'b0, "wrap up");
        chk("R5 wrap to 0000", par_q, 16'h0000);
        // Store then read back
        run_cmd(4'b0100, 16'hBEEF, 4'b0, "store");
        run_cmd(4'b1000, 16'hFFFF, 4'b0, "");
        run_cmd(4'b0010, 16'h0, 4'b0, "readback");
        chk("R3 readback", pdr_q, 16'hBEEF);
        // Lock
        panel_lock = 1'b1;
        run_cmd(4'b1000, 16'h1111, 4'b0, "lock");
        run_cmd(4'b0100, 16'h2222, 4'b0, "lock");
        run_cmd(4'b0011, 16'h3333, 4'b0, "lock");
        panel_lock = 1'b0;
        // Priority
        run_cmd(4'b1111, 16'h0040, 4'b0, "R8");
        chk("R8 load wins", par_q, 16'h0040);
        run_cmd(4'b0111, 16'h7777, 4'b0, "R8");
        chk("R8 store wins", pdr_q, 16'h7777);
        run_cmd(4'b0011, 16'h0, 4'b0, "R8");
        chk("R8 next wins", par_q, 16'h0041);
        // Busy injection
        run_cmd(4'b0010, 16'h0, 4'b1000, "R7 inj");
        run_cmd(4'b1000, 16'h0010, 4'b0100, "R7 inj");

        // Debug mode live switches
        prog_mode = 1'b0; sel_dbus = 1'b1;
        switches = 16'h1234; #1;
        chk("R9 dbus", data_bus, 16'h1234);
        chk("R9 den/aen", {14'b0, data_en, addr_en}, 16'h2);
        switches = 16'hABCD; #1;
        chk("R9 live change", data_bus, 16'hABCD);
        sel_dbus = 1'b0; sel_abus = 1'b1; switches = 16'h0F0F; #1;
        chk("R9 abus", addr_bus, 16'h0F0F);
        chk("R9 den/aen 2", {14'b0, data_en, addr_en}, 16'h1);
        @(negedge clk);
        run_cmd(4'b1000, 16'h5555, 4'b0, "dbg");
        sel_abus = 1'b0;
        prog_mode = 1'b1;

        // Random mix
        for (int k = 0; k < 500; k++) begin
            prog_mode  = ($urandom % 8) != 0;
            panel_lock = ($urandom % 6) == 0;
            sel_dbus   = !prog_mode && $urandom[0];
            sel_abus   = !prog_mode && $urandom[0];
            run_cmd(4'($urandom), 16'($urandom), ($urandom % 3 == 0) ? 4'($urandom) : 4'b0, "rand");
            @(negedge clk);
        end
        report();
    end

endmodule